// File: doc/BRIEF.md
# Zero-Crossing Digital Volume Control

This block is a digital gain stage for a stream of 16-bit two's-complement audio samples. The same block is placed once on the capture path and once on the playback path. A 5-bit gain code selects a scale factor in 1.5 dB steps. Code 23 is unity gain, code 31 is +12 dB, and code 0 is -34.5 dB. Each scaled result is clamped to the signed 16-bit range.

Software changes the volume by presenting a new code on the request input. The new code is not used at once. It is held as pending until the audio signal passes through zero. If the signal never passes through zero, the code is forced in after 256 sample frames. This keeps a step in gain from landing on a large signal value, where it would make an audible click.

Top module: `zc_volume`

## Requirements
- R1: After reset, the applied gain code is 23, the output sample is 0 and the output strobe is low.
- R2: Code c scales by a Q12 multiplier equal to the rounded value of 4096·10^((c−23)·1.5/20). The output is the product divided by 4096 and rounded toward negative infinity. Code 23 passes samples through unchanged.
- R3: Each input strobe produces exactly one output strobe, one clock later. The scaled sample is valid with that output strobe.
- R4: A scaled value above 32767 is output as 32767, and one below −32768 is output as −32768.
- R5: A request is any change of the requested-code input from the last value it held. The new code becomes pending, and the applied code stays the same until a crossing or a timeout. A request seen in the same cycle as a strobe becomes pending only after that sample.
- R6: A sample is a zero crossing if it equals 0, or if its sign bit differs from the sign bit of the previous strobed sample. The previous sample counts as non-negative after reset. At a zero crossing the pending code becomes the applied code, and the scaled output of that same sample uses it.
- R7: If 255 strobes go by after a request with no zero crossing, the 256th strobe applies the pending code, and that sample is scaled with it.
- R8: A second request made while one is pending replaces the pending code and starts the 256-strobe count again from zero.
- R9: Sample values present while the strobe is low have no effect. They do not change the output, the applied code, or the sign history used to detect crossings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Input sample strobe, one per frame |
| smp_in | input | 16 | Input sample, two's complement |
| gain_req | input | 5 | Requested gain code |
| out_valid | output | 1 | Output sample strobe |
| smp_out | output | 16 | Scaled and saturated sample |
| gain_cur | output | 5 | Gain code currently applied |

## Verification
A table of vectors checks the scaling, and that a new code is deferred. The vectors cover:
- positive-to-negative and negative-to-positive sign flips;
- an exact zero sample;
- runs of samples with the same sign, which must hold the pending code back;
- large values that must clip at each end of the range.

Directed runs then send long runs of same-sign samples. One run shows that the forced apply lands on the 256th frame and not the 255th. Another makes a second request partway through a run, to tell a restarted count apart from one that kept going. A negative value held on the sample input while the strobe is low shows that only strobed samples count toward crossing detection.

// File: rtl/zcv_pkg.sv
package zcv_pkg;

    localparam int unsigned ZCV_FRAC_W = 12;
    localparam int unsigned ZCV_MULT_W = 15;
    localparam int unsigned ZCV_CODES  = 32;

    // Q12 scale per code, 1.5 dB per step, code 23 = unity
    localparam logic [ZCV_MULT_W-1:0] ZCV_GAIN_Q12 [ZCV_CODES] = '{
        15'd77,    15'd92,    15'd109,   15'd130,
        15'd154,   15'd183,   15'd217,   15'd258,
        15'd307,   15'd365,   15'd434,   15'd516,
        15'd613,   15'd728,   15'd866,   15'd1029,
        15'd1223,  15'd1453,  15'd1727,  15'd2053,
        15'd2440,  15'd2900,  15'd3446,  15'd4096,
        15'd4868,  15'd5786,  15'd6876,  15'd8173,
        15'd9713,  15'd11544, 15'd13720, 15'd16306
    };

    typedef struct packed {
        logic [4:0] cur;
        logic [4:0] pend_code;
        logic       pend;
        logic [7:0] cnt;
        logic [4:0] last_req;
        logic       prev_neg;
    } zcv_ctl_t;

endpackage

// File: rtl/zcv_gain_rom.sv
module zcv_gain_rom
    import zcv_pkg::*;
#(
    parameter int unsigned CODE_W = 5
) (
    input  logic [CODE_W-1:0]     code,
    output logic [ZCV_MULT_W-1:0] mult
);
    localparam int unsigned NUM = 1 << CODE_W;

    logic [ZCV_MULT_W-1:0] table_w [NUM];

    for (genvar i = 0; i < NUM; i++) begin : g_entry
        assign table_w[i] = ZCV_GAIN_Q12[i];
    end

    assign mult = table_w[code];
endmodule

// File: rtl/zcv_scaler.sv
module zcv_scaler #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned MULT_W = 15,
    parameter int unsigned FRAC_W = 12
) (
    input  logic [DATA_W-1:0] x,
    input  logic [MULT_W-1:0] m,
    output logic [DATA_W-1:0] y
);
    localparam int unsigned PROD_W = DATA_W + MULT_W + 1;
    localparam logic signed [PROD_W-1:0] MAX_V = PROD_W'((1 << (DATA_W-1)) - 1);
    localparam logic signed [PROD_W-1:0] MIN_V = -PROD_W'(1 << (DATA_W-1));

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;

    always_comb begin
        prod    = PROD_W'($signed(x)) * $signed({{(PROD_W-MULT_W){1'b0}}, m});
        shifted = prod >>> FRAC_W;
        if (shifted > MAX_V) begin
            y = MAX_V[DATA_W-1:0];
        end else if (shifted < MIN_V) begin
            y = MIN_V[DATA_W-1:0];
        end else begin
            y = shifted[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/zcv_update_ctl.sv
module zcv_update_ctl
    import zcv_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned TIMEOUT    = 256,
    parameter int unsigned RESET_CODE = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_in,
    input  logic [4:0]        gain_req,
    output logic [4:0]        code_use,
    output logic [4:0]        gain_cur
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    zcv_ctl_t ctl_d, ctl_q;
    logic     zc, apply;

    always_comb begin
        zc    = smp_valid && ((smp_in == '0) || (smp_in[DATA_W-1] != ctl_q.prev_neg));
        apply = smp_valid && ctl_q.pend && (zc || (ctl_q.cnt[CNT_W-1:0] == CNT_LAST));
        code_use = apply ? ctl_q.pend_code : ctl_q.cur;

        ctl_d = ctl_q;
        if (smp_valid) begin
            ctl_d.prev_neg = smp_in[DATA_W-1];
            if (ctl_q.pend) begin
                if (apply) begin
                    ctl_d.cur  = ctl_q.pend_code;
                    ctl_d.pend = 1'b0;
                    ctl_d.cnt  = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 8'd1;
                end
            end
        end
        if (gain_req != ctl_q.last_req) begin
            ctl_d.last_req  = gain_req;
            ctl_d.pend_code = gain_req;
            ctl_d.pend      = 1'b1;
            ctl_d.cnt       = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.cur       <= 5'(RESET_CODE);
            ctl_q.pend_code <= 5'(RESET_CODE);
            ctl_q.pend      <= 1'b0;
            ctl_q.cnt       <= '0;
            ctl_q.last_req  <= 5'(RESET_CODE);
            ctl_q.prev_neg  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign gain_cur = ctl_q.cur;

    // R5/R6: applied code only moves on a strobe while something is pending
    a_r6_change_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.cur != $past(ctl_q.cur)) |-> ($past(smp_valid) && $past(ctl_q.pend)));

    // R5: the new applied code is the one that was pending
    a_r5_takes_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.cur != $past(ctl_q.cur)) |-> (ctl_q.cur == $past(ctl_q.pend_code)));

    // R7: a full count forces the pending code in
    a_r7_timeout_apply: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && ctl_q.pend && ctl_q.cnt[CNT_W-1:0] == CNT_LAST && gain_req == ctl_q.last_req)
        |=> (!ctl_q.pend && ctl_q.cur == $past(ctl_q.pend_code)));
endmodule

// File: rtl/zc_volume.sv
module zc_volume
    import zcv_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned CODE_W     = 5,
    parameter int unsigned TIMEOUT    = 256,
    parameter int unsigned RESET_CODE = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_in,
    input  logic [CODE_W-1:0] gain_req,
    output logic              out_valid,
    output logic [DATA_W-1:0] smp_out,
    output logic [CODE_W-1:0] gain_cur
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } out_t;

    logic [CODE_W-1:0]     code_use;
    logic [ZCV_MULT_W-1:0] mult;
    logic [DATA_W-1:0]     scaled;
    out_t                  out_d, out_q;

    zcv_update_ctl #(
        .DATA_W(DATA_W), .TIMEOUT(TIMEOUT), .RESET_CODE(RESET_CODE)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_in(smp_in),
        .gain_req(gain_req), .code_use(code_use), .gain_cur(gain_cur)
    );

    zcv_gain_rom #(.CODE_W(CODE_W)) u_rom (.code(code_use), .mult(mult));

    zcv_scaler #(
        .DATA_W(DATA_W), .MULT_W(ZCV_MULT_W), .FRAC_W(ZCV_FRAC_W)
    ) u_scale (.x(smp_in), .m(mult), .y(scaled));

    always_comb begin
        out_d       = out_q;
        out_d.valid = smp_valid;
        if (smp_valid) begin
            out_d.data = scaled;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign smp_out   = out_q.data;

    // R3: one output strobe per input strobe, one clock later
    a_r3_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(smp_valid));

    // R2: a zero sample scales to zero at every code
    a_r2_zero_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_in == '0) |=> (smp_out == '0));

    // R9: without a strobe the output holds
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(smp_out));
endmodule

// File: tb/zc_volume_tb.sv
module zc_volume_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_in = '0;
    logic [4:0]  gain_req = 5'd23;
    logic        out_valid;
    logic [15:0] smp_out;
    logic [4:0]  gain_cur;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    zc_volume u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_in(smp_in),
        .gain_req(gain_req), .out_valid(out_valid), .smp_out(smp_out), .gain_cur(gain_cur)
    );

    // fields: has_req, req code, sample, expected applied code
    typedef struct packed {
        logic        has_req;
        logic [4:0]  req;
        logic [15:0] smp;
        logic [4:0]  exp_code;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd0,  16'sd1000,   5'd23},  // R2 unity
        '{1'b1, 5'd31, 16'sd2000,   5'd23},  // R5 deferred
        '{1'b0, 5'd0,  -16'sd500,   5'd31},  // R6 pos->neg
        '{1'b0, 5'd0,  16'sd10000,  5'd31},  // R4 clip high
        '{1'b0, 5'd0,  -16'sd20000, 5'd31},  // R4 clip low
        '{1'b1, 5'd0,  -16'sd100,   5'd31},  // R5 same sign
        '{1'b0, 5'd0,  16'sd0,      5'd0},   // R6 exact zero
        '{1'b1, 5'd15, 16'sd5,      5'd0},   // R5
        '{1'b1, 5'd19, 16'sd300,    5'd0},   // R8 replace
        '{1'b0, 5'd0,  -16'sd300,   5'd19},  // R8 replaced code used
        '{1'b1, 5'd23, 16'sd32767,  5'd23},  // R6 neg->pos
        '{1'b0, 5'd0,  -16'sd32768, 5'd23},  // R2 extreme
        '{1'b1, 5'd27, -16'sd1,     5'd23},  // R5
        '{1'b0, 5'd0,  16'sd1,      5'd27}   // R6
    };

    function automatic real expect_out(int x, int code);
        real e;
        e = real'(x) * (10.0 ** ((real'(code) - 23.0) * 0.075));
        if (e > 32767.0) e = 32767.0;
        if (e < -32768.0) e = -32768.0;
        return e;
    endfunction

    task automatic chk_code(string req, logic [4:0] exp);
        checks++;
        if (gain_cur !== exp) begin
            fails++;
            $display("FAIL %s gain_cur actual=%0d expected=%0d", req, gain_cur, exp);
        end
    endtask

    task automatic chk_out(string req, int x, int code);
        real e, d, tol;
        e   = expect_out(x, code);
        d   = real'($signed(smp_out)) - e;
        tol = 1.0 + ((x < 0) ? -real'(x) : real'(x)) / 2048.0;
        checks++;
        if (out_valid !== 1'b1 || d > tol || d < -tol) begin
            fails++;
            $display("FAIL %s smp_out actual=%0d expected=%0.2f valid=%0b", req,
                     $signed(smp_out), e, out_valid);
        end
    endtask

    task automatic request(logic [4:0] c);
        @(negedge clk);
        gain_req = c;
        @(negedge clk);
    endtask

    task automatic send(int x);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_in    = 16'(x);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (gain_cur !== 5'd23 || smp_out !== 16'd0 || out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset actual code=%0d out=%0d valid=%0b expected 23/0/0",
                     gain_cur, smp_out, out_valid);
        end
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].has_req) request(VECS[i].req);
            send(int'($signed(VECS[i].smp)));
            chk_code("R6 vector", VECS[i].exp_code);
            chk_out("R2 vector", int'($signed(VECS[i].smp)), int'(VECS[i].exp_code));
        end

        // R3: strobe is one cycle wide
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R3 out_valid actual=%0b expected=0", out_valid);
        end

        // R7 timeout: state code 27, prev positive
        request(5'd10);
        for (int k = 0; k < 255; k++) send(1200);
        chk_code("R7 before timeout", 5'd27);
        send(1200);
        chk_code("R7 at timeout", 5'd10);
        chk_out("R7 timeout sample", 1200, 10);

        // R8 restart: two requests, 200 frames apart
        request(5'd20);
        for (int k = 0; k < 200; k++) send(800);
        request(5'd29);
        for (int k = 0; k < 200; k++) send(800);
        chk_code("R8 old count not used", 5'd10);
        for (int k = 0; k < 55; k++) send(800);
        chk_code("R8 before restarted timeout", 5'd10);
        send(800);
        chk_code("R8 restarted timeout", 5'd29);
        chk_out("R8 timeout sample", 800, 29);

        // R9: values without strobe are ignored
        request(5'd23);
        @(negedge clk);
        smp_in = -16'sd5000;
        repeat (4) @(negedge clk);
        checks++;
        if (gain_cur !== 5'd29 || $signed(smp_out) == -16'sd5000) begin
            fails++;
            $display("FAIL R9 idle input actual code=%0d out=%0d expected code 29",
                     gain_cur, $signed(smp_out));
        end
        send(700);
        chk_code("R9 no false crossing", 5'd29);
        chk_out("R9 sample", 700, 29);
        send(-700);
        chk_code("R6 after idle", 5'd23);
        chk_out("R6 after idle", -700, 23);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule